// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Bypass

This block sits between a write-through data cache and a slower memory port. Each store the processor makes goes into the cache and, in the same cycle, into a small queue of address/data pairs here. A drain engine empties the queue toward memory one entry at a time, oldest first, over a request/acknowledge write interface. While the queue holds entries it stalls further stores once every slot is taken.

Read misses from the cache come through the same block. Each read address is compared, at word granularity, with every occupied entry. If some entries match, the youngest one answers the read directly and memory is left alone. If none match, the read takes the memory port ahead of the queued writes. It only waits for a drain write that is already on the bus. The requester holds `rd_valid` and `rd_addr` until `rd_done` pulses, and drops `rd_valid` in the cycle that follows.

Top module: `wt_store_buffer`

## Requirements
- R1: After reset `buf_empty` is 1, `buf_full` and `st_stall` are 0, and `mem_req` and `rd_done` are 0.
- R2: A store is taken on a clock edge where `st_valid` is 1 and `st_stall` is 0. With DEPTH (default 4) entries held, `buf_full` and `st_stall` are 1 and a presented store is not taken until an entry has been drained.
- R3: Held entries are written to memory (`mem_req`=1, `mem_we`=1) in the order the stores were taken. Every taken store is written exactly once, and an entry is retired on the edge where `mem_ack` is 1.
- R4: A read whose word address matches no held entry is sent to memory with `mem_we`=0 without waiting for the queue to empty. It completes with `rd_done`=1, `rd_fwd`=0 and `rd_data` equal to the last value stored to that word.
- R5: A read whose word address matches one or more held entries returns the data of the most recently taken matching entry with `rd_fwd`=1. `rd_done` pulses one cycle after the read is presented, and no memory read is issued for it.
- R6: A read miss that arrives while a drain write is outstanding waits for that one write's acknowledge. It then takes the memory port before any further drain write.
- R7: Addresses compare on word boundaries: the low log2(DW/8) bits of store and read addresses are ignored. Entries already retired never match.
- R8: A store taken on the same edge that an entry retires leaves the occupancy unchanged. After any store stream the queue drains to empty, with the number of memory writes equal to the number of stores taken.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle. `mem_addr` is word-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store cannot be taken this cycle |
| rd_valid | input | 1 | Read miss presented, held until `rd_done` |
| rd_addr | input | AW | Read byte address |
| rd_done | output | 1 | One-cycle pulse: read result valid |
| rd_data | output | DW | Read result |
| rd_fwd | output | 1 | Result came from the queue rather than memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory completes the request on this edge |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| buf_full | output | 1 | All entries occupied |
| buf_empty | output | 1 | No entry occupied |

## Verification
Reads are tried in four situations: a word stored twice and still queued, a word queued under a different byte offset, a word whose store has already drained, and a word never queued while four writes wait on a slow memory. Together these separate youngest-entry forwarding from oldest-entry forwarding, word-granular comparison from byte comparison, and stale-slot matching from a correct miss. They also distinguish a true bypass from a read that waits for the whole queue. A slow memory with a full queue shows whether the stall holds and releases after exactly one retirement. A zero-latency memory with a steady store stream makes stores and retirements coincide. A long seeded random mix of stores, reads and memory latencies checks drain order and read data against a shadow of the last value stored to each word.

// File: rtl/wtb_pkg.sv
package wtb_pkg;

  // Memory-port owner state.
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WRITE = 2'd1,
    ARB_READ  = 2'd2
  } arb_state_e;

  // Mask that clears the byte-offset bits of an address.
  function automatic logic [63:0] word_mask(input int offs);
    logic [63:0] m;
    m = '1;
    m = m << offs;
    return m;
  endfunction

endpackage

// File: rtl/wtb_fifo.sv
module wtb_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic                      full,
  output logic                      empty,
  output logic                      last_one,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [$clog2(DEPTH)-1:0]  rd_ptr,
  output logic [DEPTH-1:0]          slot_valid,
  output logic [DEPTH-1:0][AW-1:0]  slot_addr,
  output logic [DEPTH-1:0][DW-1:0]  slot_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]             wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic [DEPTH-1:0]          vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;

  // Next-state: pointers, per-slot valid flags, occupancy.
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    vld_d    = vld_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d         = wr_ptr_q + PW'(1);
      vld_d[wr_ptr_q]  = 1'b1;
    end
    if (pop) begin
      rd_ptr_d         = rd_ptr_q + PW'(1);
      vld_d[rd_ptr_q]  = 1'b0;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      vld_q    <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      vld_q    <= vld_d;
      cnt_q    <= cnt_d;
    end
  end

  // Payload storage: enabled write, no reset.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  assign full       = (cnt_q == CW'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign last_one   = (cnt_q == CW'(1));
  assign head_addr  = addr_q[rd_ptr_q];
  assign head_data  = data_q[rd_ptr_q];
  assign rd_ptr     = rd_ptr_q;
  assign slot_valid = vld_q;
  assign slot_addr  = addr_q;
  assign slot_data  = data_q;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_valid_matches_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
  p_occ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> cnt_q == $past(cnt_q));
  p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_no_push_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/wtb_match.sv
module wtb_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int OFFS  = 2
) (
  input  logic [DEPTH-1:0]          slot_valid,
  input  logic [DEPTH-1:0][AW-1:0]  slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]  slot_data,
  input  logic [$clog2(DEPTH)-1:0]  rd_ptr,
  input  logic [AW-1:0]             probe_addr,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] MASK = AW'(wtb_pkg::word_mask(OFFS));

  logic [DEPTH-1:0] slot_eq;

  // One word comparator per slot; retired slots never match.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_eq[g] = slot_valid[g] &&
                        ((slot_addr[g] & MASK) == (probe_addr & MASK));
  end

  // Walk from oldest to youngest so the last match found wins.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_eq[rd_ptr + PW'(i)]) begin
        hit      = 1'b1;
        hit_data = slot_data[rd_ptr + PW'(i)];
      end
    end
  end

endmodule

// File: rtl/wtb_arb.sv
module wtb_arb #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          empty,
  input  logic          last_one,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          pop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          rd_fwd
);
  import wtb_pkg::*;

  localparam logic [AW-1:0] MASK = AW'(word_mask(OFFS));

  arb_state_e    state_q, state_d;
  logic          done_q, done_d;
  logic [DW-1:0] data_q, data_d;
  logic          fwd_q, fwd_d;
  logic [AW-1:0] raddr_q, raddr_d;
  logic          raddr_en;
  logic          rd_pend;

  assign rd_pend = rd_valid && !done_q;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    data_d   = data_q;
    fwd_d    = fwd_q;
    raddr_d  = raddr_q;
    raddr_en = 1'b0;
    pop      = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (rd_pend && hit) begin
          done_d = 1'b1;
          data_d = hit_data;
          fwd_d  = 1'b1;
        end else if (rd_pend) begin
          state_d  = ARB_READ;
          raddr_d  = rd_addr & MASK;
          raddr_en = 1'b1;
        end else if (!empty) begin
          state_d = ARB_WRITE;
        end
      end
      ARB_WRITE: begin
        if (rd_pend && hit) begin
          done_d = 1'b1;
          data_d = hit_data;
          fwd_d  = 1'b1;
        end
        if (mem_ack) begin
          pop = 1'b1;
          if (rd_pend && !hit) begin
            state_d  = ARB_READ;
            raddr_d  = rd_addr & MASK;
            raddr_en = 1'b1;
          end else if (last_one) begin
            state_d = ARB_IDLE;
          end else begin
            state_d = ARB_WRITE;
          end
        end
      end
      ARB_READ: begin
        if (mem_ack) begin
          done_d  = 1'b1;
          data_d  = mem_rdata;
          fwd_d   = 1'b0;
          state_d = ARB_IDLE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      done_q  <= 1'b0;
      data_q  <= '0;
      fwd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      data_q  <= data_d;
      fwd_q   <= fwd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (raddr_en) raddr_q <= raddr_d;
  end

  assign mem_req   = (state_q != ARB_IDLE);
  assign mem_we    = (state_q == ARB_WRITE);
  assign mem_addr  = (state_q == ARB_WRITE) ? (head_addr & MASK) : raddr_q;
  assign mem_wdata = (state_q == ARB_WRITE) ? head_data : '0;
  assign rd_done   = done_q;
  assign rd_data   = data_q;
  assign rd_fwd    = fwd_q;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) &&
                             $stable(mem_addr) && $stable(mem_wdata));
  p_write_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !empty);
  p_read_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && rd_valid && !rd_done && !hit
    |=> mem_req && !mem_we);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  p_mem_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !rd_fwd |-> $past(mem_req && mem_ack && !mem_we));

endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          rd_fwd,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_full,
  output logic          buf_empty
);
  localparam int PW   = $clog2(DEPTH);
  localparam int OFFS = (DW > 8) ? $clog2(DW / 8) : 0;

  logic                      push, pop, full, empty, last_one, hit;
  logic [AW-1:0]             head_addr;
  logic [DW-1:0]             head_data, hit_data;
  logic [PW-1:0]             rd_ptr;
  logic [DEPTH-1:0]          slot_valid;
  logic [DEPTH-1:0][AW-1:0]  slot_addr;
  logic [DEPTH-1:0][DW-1:0]  slot_data;

  assign push = st_valid && !full;

  wtb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop),
    .full(full), .empty(empty), .last_one(last_one),
    .head_addr(head_addr), .head_data(head_data),
    .rd_ptr(rd_ptr), .slot_valid(slot_valid),
    .slot_addr(slot_addr), .slot_data(slot_data)
  );

  wtb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .OFFS(OFFS)) u_match (
    .slot_valid(slot_valid), .slot_addr(slot_addr), .slot_data(slot_data),
    .rd_ptr(rd_ptr), .probe_addr(rd_addr),
    .hit(hit), .hit_data(hit_data)
  );

  wtb_arb #(.AW(AW), .DW(DW), .OFFS(OFFS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .hit(hit), .hit_data(hit_data),
    .empty(empty), .last_one(last_one),
    .head_addr(head_addr), .head_data(head_data),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pop(pop),
    .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_done(rd_done), .rd_data(rd_data), .rd_fwd(rd_fwd)
  );

  assign st_stall  = full;
  assign buf_full  = full;
  assign buf_empty = empty;

  p_full_until_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !pop |=> buf_full);
  p_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty));

endmodule

// File: tb/test_wt_store_buffer.sv
module test_wt_store_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, rd_valid, mem_ack;
  logic [31:0] st_addr, st_data, rd_addr, mem_rdata;
  logic        st_stall, rd_done, rd_fwd, mem_req, mem_we, buf_full, buf_empty;
  logic [31:0] rd_data, mem_addr, mem_wdata;

  always #5 clk = ~clk;

  wt_store_buffer i_wt_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .rd_fwd(rd_fwd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_full(buf_full), .buf_empty(buf_empty)
  );

  // Bench state owned by the main sequence.
  int          checks = 0;
  int          fails  = 0;
  int          stores_total = 0;
  int          mem_lat = 0;
  logic [31:0] arch [16];
  logic [31:0] pq_a [$];
  logic [31:0] pq_d [$];

  // Bench state owned by the memory model.
  logic [31:0] mem_arr [16];
  int          drain_idx = 0;
  int          writes_done = 0;
  int          mem_rd_cnt = 0;
  int          drain_chk = 0;
  int          drain_bad = 0;
  int          wait_cnt = 0;
  int          r9_bad = 0;
  int          full_cnt = 0;
  logic [31:0] hold_addr;
  logic        hold_we;

  function automatic logic [3:0] widx(input logic [31:0] a);
    return a[5:2];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: acknowledge and read data are set at the falling edge.
  always @(negedge clk) begin
    if (buf_full) full_cnt++;
    if (mem_req) begin
      if (wait_cnt == 0) begin
        hold_addr = mem_addr;
        hold_we   = mem_we;
      end else if (mem_addr != hold_addr || mem_we != hold_we) begin
        r9_bad++;
      end
      if (wait_cnt >= mem_lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_arr[widx(mem_addr)];
        wait_cnt  = 0;
      end else begin
        mem_ack = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  // Memory model: the transfer completes on the rising edge with acknowledge.
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        drain_chk++;
        if (mem_addr[1:0] != 2'b00 || drain_idx >= pq_a.size() ||
            mem_addr[31:2] != pq_a[drain_idx][31:2] || mem_wdata != pq_d[drain_idx]) begin
          drain_bad++;
          $display("FAIL R3 drain order actual=%0h/%0h expected=%0h/%0h", mem_addr,
                   mem_wdata, (drain_idx < pq_a.size()) ? pq_a[drain_idx] : 32'hx,
                   (drain_idx < pq_d.size()) ? pq_d[drain_idx] : 32'hx);
        end
        mem_arr[widx(mem_addr)] = mem_wdata;
        drain_idx++;
        writes_done++;
      end else begin
        mem_rd_cnt++;
      end
    end
  end

  // Completes a store whose inputs are already driven.
  task automatic store_wait(input logic [31:0] a, input logic [31:0] d);
    bit ok;
    while (1) begin
      ok = !st_stall;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    pq_a.push_back(a);
    pq_d.push_back(d);
    arch[widx(a)] = d;
    stores_total++;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    store_wait(a, d);
  endtask

  task automatic do_read(input logic [31:0] a, output int lat);
    bit          exp_fwd;
    logic [31:0] exp_d;
    int          rd0;
    @(negedge clk);
    exp_fwd = 1'b0;
    for (int i = drain_idx; i < pq_a.size(); i++)
      if (pq_a[i][31:2] == a[31:2]) exp_fwd = 1'b1;
    exp_d    = arch[widx(a)];
    rd0      = mem_rd_cnt;
    rd_valid = 1'b1;
    rd_addr  = a;
    lat      = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rd_done);
    rd_valid = 1'b0;
    if (exp_fwd) begin
      chk(rd_data == exp_d, "R5 forwarded data", rd_data, exp_d);
      chk(rd_fwd == 1'b1, "R5 forward flag", 32'(rd_fwd), 32'd1);
      chk(mem_rd_cnt == rd0, "R5 no memory read", 32'(mem_rd_cnt - rd0), 32'd0);
    end else begin
      chk(rd_data == exp_d, "R4 memory data", rd_data, exp_d);
      chk(rd_fwd == 1'b0, "R4 forward flag", 32'(rd_fwd), 32'd0);
      chk(mem_rd_cnt == rd0 + 1, "R4 one memory read", 32'(mem_rd_cnt - rd0), 32'd1);
    end
  endtask

  task automatic wait_empty();
    do @(negedge clk); while (!buf_empty || mem_req);
  endtask

  // Watchdog: a hung run counts as a failed check.
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int lat, wb, fb, nr;
    bit stall_ok;
    logic [31:0] a, d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      arch[i]    = '0;
      mem_arr[i] = '0;
    end
    rst_n = 1'b0; st_valid = 1'b0; rd_valid = 1'b0;
    st_addr = '0; st_data = '0; rd_addr = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(buf_empty == 1'b1, "R1 empty", 32'(buf_empty), 32'd1);
    chk(buf_full == 1'b0 && st_stall == 1'b0, "R1 full/stall", 32'(buf_full), 32'd0);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    chk(rd_done == 1'b0, "R1 rd_done", 32'(rd_done), 32'd0);
    rst_n = 1'b1;

    // R5: youngest of two matching entries, answered one cycle later
    mem_lat = 20;
    do_store(32'h0000_000C, 32'h1111_0001);
    do_store(32'h0000_000C, 32'h2222_0002);
    do_read(32'h0000_000C, lat);
    chk(lat == 1, "R5 forward latency", 32'(lat), 32'd1);

    // R7: byte offsets ignored in the comparison
    do_store(32'h0000_0015, 32'h3333_0003);
    do_read(32'h0000_0017, lat);
    chk(rd_fwd == 1'b1, "R7 word compare", 32'(rd_fwd), 32'd1);

    // R7: retired entries no longer match
    wait_empty();
    do_read(32'h0000_0014, lat);
    chk(rd_fwd == 1'b0, "R7 retired entry ignored", 32'(rd_fwd), 32'd0);

    // R2: fill the queue and hold a fifth store
    for (int i = 0; i < 4; i++) do_store(32'(i * 4 + 32), 32'h4400_0000 + 32'(i));
    @(negedge clk);
    chk(buf_full == 1'b1 && st_stall == 1'b1, "R2 full at depth", 32'(buf_full), 32'd1);
    st_valid = 1'b1; st_addr = 32'h0000_0024; st_data = 32'h5555_0005;
    stall_ok = 1'b1;
    wb = writes_done;
    repeat (3) begin
      if (!st_stall) stall_ok = 1'b0;
      @(negedge clk);
    end
    chk(stall_ok, "R2 store held while full", 32'(stall_ok), 32'd1);
    store_wait(32'h0000_0024, 32'h5555_0005);
    chk(writes_done == wb + 1, "R2 taken after one drain", 32'(writes_done - wb), 32'd1);
    wait_empty();
    chk(writes_done == stores_total, "R3 every store written", 32'(writes_done),
        32'(stores_total));

    // R4 and R6: read miss bypasses three queued writes, waits for one
    mem_lat = 10;
    for (int i = 0; i < 4; i++) do_store(32'(i * 4), 32'h6600_0000 + 32'(i));
    wb = writes_done;
    do_read(32'h0000_0028, lat);
    chk(buf_empty == 1'b0, "R4 queue not empty at read completion", 32'(buf_empty), 32'd0);
    chk(writes_done == wb + 1, "R6 waits for the in-flight write only",
        32'(writes_done - wb), 32'd1);
    wait_empty();

    // R8: store stream against a zero-latency memory
    mem_lat = 0;
    fb = full_cnt;
    wb = writes_done;
    for (int i = 0; i < 12; i++) do_store(32'(i * 4 + 1), 32'h7700_0000 + 32'(i));
    wait_empty();
    chk(full_cnt == fb, "R8 occupancy never reaches full", 32'(full_cnt - fb), 32'd0);
    chk(writes_done - wb == 12, "R8 writes equal stores", 32'(writes_done - wb), 32'd12);

    // Seeded random mix of stores and reads
    nr = 0;
    for (int n = 0; n < 400; n++) begin
      if (n % 8 == 0) mem_lat = int'($urandom_range(0, 5));
      a = {26'd0, 3'($urandom_range(0, 7)), 1'b0, 2'($urandom_range(0, 3))};
      d = $urandom;
      if ($urandom_range(0, 9) < 6) do_store(a, d);
      else begin
        do_read(a, lat);
        nr++;
      end
    end
    wait_empty();
    chk(writes_done == stores_total, "R8 totals after random mix", 32'(writes_done),
        32'(stores_total));
    chk(nr > 0, "R4 random reads issued", 32'(nr), 32'd1);
    chk(r9_bad == 0, "R9 request held until acknowledge", 32'(r9_bad), 32'd0);

    checks += drain_chk;
    fails  += drain_bad;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule